// File: doc/BRIEF.md
# Calendar Alarm Comparator

This block watches a running calendar, supplied from outside as BCD fields for seconds, minutes, hours, weekday, day, month and year, and raises an alarm when the calendar reaches a time that software has programmed. Each of the seven alarm fields carries its own participate flag, so any subset of fields can take part in the comparison. One example is a full-date alarm that ignores the day of the week.

Software writes the alarm fields through a small register port. The writes land in a staging copy and have no effect until a commit word is written, so all fields change together. The comparison runs once per one-second tick. When every participating field equals the calendar, a sticky status bit is set. The interrupt request is the status bit gated by an interrupt enable bit. The status bit is cleared by writing one to it.

Register map (word addresses): 0 seconds (7 value bits), 1 minutes (7), 2 hours (6), 3 weekday (3), 4 day (6), 5 month (5), 6 year (8). Bit 15 of each of these words is the participate flag. Address 7 is the commit word, which acts when its bit 15 is one. Address 8 holds the interrupt enable in bit 0. Address 9 holds the status in bit 0.

Top module: `calendar_alarm`

## Requirements
- R1: After reset, every committed alarm word reads zero with its flag clear, and the enable bit, the status bit and irq are all 0.
- R2: A write to an alarm field (addresses 0 to 6) changes nothing that can be read back or matched. A write to address 7 with bit 15 clear also has no effect.
- R3: Writing address 7 with bit 15 set copies all seven staged fields, values and flags, into the committed alarm in the cycle after the write. The committed alarm changes at no other time.
- R4: On a cycle with sec_tick high, if every flagged committed field equals its calendar input, the status bit reads 1 from the next cycle on.
- R5: Without sec_tick the status bit never sets, even while the fields match.
- R6: A field whose flag (bit 15) is clear does not take part in the comparison. This makes a weekday-ignoring date alarm possible.
- R7: If no committed field has its flag set, the alarm never matches.
- R8: The status bit is sticky. Writing address 9 with bit 0 set clears it, and writing 0 there leaves it unchanged. A set on a tick wins over a clear in the same cycle.
- R9: irq equals the status bit AND enable bit 0 of address 8.
- R10: Value bits above a field's width are dropped on write and read back as zero. Each field reads back as {flag at bit 15, value in the low bits}.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register write address |
| wr_data | input | 16 | Register write data |
| rd_addr | input | 4 | Register read address |
| rd_data | output | 16 | Register read data, combinational |
| sec_tick | input | 1 | One-cycle pulse once per second |
| cal_sec | input | 7 | Calendar seconds, BCD |
| cal_min | input | 7 | Calendar minutes, BCD |
| cal_hour | input | 6 | Calendar hours, BCD |
| cal_wday | input | 3 | Calendar weekday |
| cal_day | input | 6 | Calendar day of month, BCD |
| cal_mon | input | 5 | Calendar month, BCD |
| cal_year | input | 8 | Calendar year, BCD |
| irq | output | 1 | Alarm interrupt request, level |

## Verification
The assertions assume that sec_tick, wr_en and the calendar fields are free of unknowns and change only away from the active clock edge. They also assume that a match and a clear in the same cycle resolve in favour of the set. The bench drives every input at the falling edge. It forces matches by copying the committed flagged fields onto the calendar inputs, and it also mixes in random calendar values, so both hits and misses occur. Writes with random data and random flags reach all addresses, including the unused upper value bits.

// File: rtl/cal_alarm_pkg.sv
package cal_alarm_pkg;
   localparam int NUM_FIELDS = 7;
   localparam int MAX_FW     = 8;

   // value width of each alarm field, in commit order
   function automatic int field_width(input int idx);
      case (idx)
         0: return 7;
         1: return 7;
         2: return 6;
         3: return 3;
         4: return 6;
         5: return 5;
         default: return 8;
      endcase
   endfunction
endpackage

// File: rtl/alarm_field_slot.sv
module alarm_field_slot #(
   parameter int DATA_W   = 16,
   parameter int FLAG_POS = 15,
   parameter int VAL_W    = 7
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              stage_we,
   input  logic              commit,
   input  logic [DATA_W-1:0] wdata,
   output logic [VAL_W-1:0]  val_q,
   output logic              flag_q
);
   logic [VAL_W-1:0] stg_val;
   logic             stg_flag;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stg_val  <= '0;
         stg_flag <= 1'b0;
         val_q    <= '0;
         flag_q   <= 1'b0;
      end else begin
         if (stage_we) begin
            stg_val  <= wdata[VAL_W-1:0];
            stg_flag <= wdata[FLAG_POS];
         end
         if (commit) begin
            val_q  <= stg_val;
            flag_q <= stg_flag;
         end
      end
   end
endmodule

// File: rtl/alarm_compare.sv
module alarm_compare #(
   parameter int NUM = 7,
   parameter int FW  = 8
) (
   input  logic [NUM-1:0]         flags,
   input  logic [NUM-1:0][FW-1:0] alarm,
   input  logic [NUM-1:0][FW-1:0] cal,
   output logic                   hit
);
   logic [NUM-1:0] field_ok;

   for (genvar i = 0; i < NUM; i++) begin : g_cmp
      assign field_ok[i] = !flags[i] || (alarm[i] == cal[i]);
   end

   assign hit = (|flags) && (&field_ok);
endmodule

// File: rtl/alarm_irq_ctrl.sv
module alarm_irq_ctrl (
   input  logic clk,
   input  logic rst_n,
   input  logic tick,
   input  logic hit,
   input  logic en_we,
   input  logic clr_we,
   input  logic wbit0,
   output logic en_q,
   output logic st_q,
   output logic irq
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q <= 1'b0;
         st_q <= 1'b0;
      end else begin
         if (en_we) en_q <= wbit0;
         if (tick && hit) st_q <= 1'b1;
         else if (clr_we) st_q <= 1'b0;
      end
   end

   assign irq = st_q & en_q;
endmodule

// File: rtl/calendar_alarm.sv
module calendar_alarm
   import cal_alarm_pkg::*;
#(
   parameter int DATA_W   = 16,
   parameter int ADDR_W   = 4,
   parameter int FLAG_POS = 15
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [DATA_W-1:0] rd_data,
   input  logic              sec_tick,
   input  logic [6:0]        cal_sec,
   input  logic [6:0]        cal_min,
   input  logic [5:0]        cal_hour,
   input  logic [2:0]        cal_wday,
   input  logic [5:0]        cal_day,
   input  logic [4:0]        cal_mon,
   input  logic [7:0]        cal_year,
   output logic              irq
);
   localparam int NF        = NUM_FIELDS;
   localparam int ADR_TRIG  = NF;
   localparam int ADR_IEN   = NF + 1;
   localparam int ADR_STAT  = NF + 2;

   if (FLAG_POS >= DATA_W || FLAG_POS < MAX_FW) begin : g_bad_flag
      $error("calendar_alarm: FLAG_POS must sit above the value bits and inside the word");
   end
   if ((1 << ADDR_W) <= ADR_STAT) begin : g_bad_addr
      $error("calendar_alarm: ADDR_W too narrow for the register map");
   end

   logic [NF-1:0]             alm_flag;
   logic [NF-1:0][MAX_FW-1:0] alm_val;
   logic [NF-1:0][MAX_FW-1:0] cal_vec;
   logic [NF-1:0][DATA_W-1:0] alm_word;
   logic                      commit;
   logic                      hit;
   logic                      en_q;
   logic                      st_q;
   logic                      clr_wr;
   logic                      en_wr;

   assign commit = wr_en && (wr_addr == ADDR_W'(ADR_TRIG)) && wr_data[FLAG_POS];
   assign en_wr  = wr_en && (wr_addr == ADDR_W'(ADR_IEN));
   assign clr_wr = wr_en && (wr_addr == ADDR_W'(ADR_STAT)) && wr_data[0];

   always_comb begin
      cal_vec    = '0;
      cal_vec[0] = MAX_FW'(cal_sec);
      cal_vec[1] = MAX_FW'(cal_min);
      cal_vec[2] = MAX_FW'(cal_hour);
      cal_vec[3] = MAX_FW'(cal_wday);
      cal_vec[4] = MAX_FW'(cal_day);
      cal_vec[5] = MAX_FW'(cal_mon);
      cal_vec[6] = MAX_FW'(cal_year);
   end

   for (genvar i = 0; i < NF; i++) begin : g_field
      localparam int W = field_width(i);
      logic [W-1:0] v;

      alarm_field_slot #(
         .DATA_W  (DATA_W),
         .FLAG_POS(FLAG_POS),
         .VAL_W   (W)
      ) u_slot (
         .clk     (clk),
         .rst_n   (rst_n),
         .stage_we(wr_en && (wr_addr == ADDR_W'(i))),
         .commit  (commit),
         .wdata   (wr_data),
         .val_q   (v),
         .flag_q  (alm_flag[i])
      );

      assign alm_val[i] = MAX_FW'(v);

      always_comb begin
         alm_word[i]           = '0;
         alm_word[i][W-1:0]    = v;
         alm_word[i][FLAG_POS] = alm_flag[i];
      end
   end

   alarm_compare #(
      .NUM(NF),
      .FW (MAX_FW)
   ) u_cmp (
      .flags(alm_flag),
      .alarm(alm_val),
      .cal  (cal_vec),
      .hit  (hit)
   );

   alarm_irq_ctrl u_irq (
      .clk   (clk),
      .rst_n (rst_n),
      .tick  (sec_tick),
      .hit   (hit),
      .en_we (en_wr),
      .clr_we(clr_wr),
      .wbit0 (wr_data[0]),
      .en_q  (en_q),
      .st_q  (st_q),
      .irq   (irq)
   );

   always_comb begin
      rd_data = '0;
      if (rd_addr < ADDR_W'(NF))          rd_data = alm_word[rd_addr[2:0]];
      else if (rd_addr == ADDR_W'(ADR_IEN))  rd_data[0] = en_q;
      else if (rd_addr == ADDR_W'(ADR_STAT)) rd_data[0] = st_q;
   end
endmodule

// File: rtl/cal_alarm_chk.sv
module cal_alarm_chk #(
   parameter int NUM = 7,
   parameter int FW  = 8
) (
   input logic                   clk,
   input logic                   rst_n,
   input logic                   sec_tick,
   input logic                   hit,
   input logic [NUM-1:0]         flags,
   input logic                   commit,
   input logic [NUM-1:0][FW-1:0] alm_vec,
   input logic                   status,
   input logic                   irq,
   input logic                   clr_wr
);
   // R7
   no_flag_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (flags == '0) |-> !hit);

   // R4
   set_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sec_tick && hit) |=> status);

   // R5
   rise_needs_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(status) |-> $past(sec_tick && hit));

   // R3
   hold_without_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !commit |=> ($stable(alm_vec) && $stable(flags)));

   // R9
   irq_needs_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> status);

   // R8
   sticky_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (status && !clr_wr) |=> status);
endmodule

bind calendar_alarm cal_alarm_chk #(
   .NUM(cal_alarm_pkg::NUM_FIELDS),
   .FW (cal_alarm_pkg::MAX_FW)
) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .sec_tick(sec_tick),
   .hit     (hit),
   .flags   (alm_flag),
   .commit  (commit),
   .alm_vec (alm_val),
   .status  (st_q),
   .irq     (irq),
   .clr_wr  (clr_wr)
);

// File: tb/calendar_alarm_test.sv
`timescale 1ns/1ps
module calendar_alarm_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [3:0]  wr_addr = '0;
   logic [15:0] wr_data = '0;
   logic [3:0]  rd_addr = '0;
   logic [15:0] rd_data;
   logic        sec_tick = 1'b0;
   logic        irq;
   logic [7:0]  cv [7];

   int total = 0;
   int bad = 0;
   bit done = 0;

   // bench model
   int  stg_val [7];
   bit  stg_flag [7];
   int  com_val [7];
   bit  com_flag [7];
   bit  m_en;
   bit  m_st;

   always #5 clk = ~clk;

   calendar_alarm uut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .rd_addr(rd_addr), .rd_data(rd_data), .sec_tick(sec_tick),
      .cal_sec(cv[0][6:0]), .cal_min(cv[1][6:0]), .cal_hour(cv[2][5:0]),
      .cal_wday(cv[3][2:0]), .cal_day(cv[4][5:0]), .cal_mon(cv[5][4:0]),
      .cal_year(cv[6]), .irq(irq)
   );

   function automatic int fw(input int i);
      case (i)
         0, 1: return 7;
         2, 4: return 6;
         3: return 3;
         5: return 5;
         default: return 8;
      endcase
   endfunction

   function automatic int fmask(input int i);
      return (1 << fw(i)) - 1;
   endfunction

   function automatic bit model_hit();
      bit any = 0;
      bit all = 1;
      for (int i = 0; i < 7; i++) begin
         if (com_flag[i]) begin
            any = 1;
            if (com_val[i] != int'(cv[i])) all = 0;
         end
      end
      return any && all;
   endfunction

   function automatic int exp_word(input int a);
      if (a < 7) return (int'(com_flag[a]) << 15) | com_val[a];
      if (a == 8) return int'(m_en);
      if (a == 9) return int'(m_st);
      return 0;
   endfunction

   task automatic check_all(input string tag);
      for (int a = 0; a < 10; a++) begin
         rd_addr = a[3:0];
         #0.2;
         total++;
         if (int'(rd_data) != exp_word(a)) begin
            bad++;
            $display("FAIL %s addr=%0d actual=%h expected=%h", tag, a, rd_data, exp_word(a));
         end
      end
      total++;
      if (irq !== (m_st & m_en)) begin
         bad++;
         $display("FAIL %s/R9 irq actual=%b expected=%b", tag, irq, m_st & m_en);
      end
   endtask

   task automatic do_write(input int a, input int d, input string tag);
      bit set_now;
      @(negedge clk);
      wr_en = 1; wr_addr = a[3:0]; wr_data = d[15:0];
      @(posedge clk);
      set_now = sec_tick && model_hit();
      if (a < 7) begin
         stg_val[a] = d & fmask(a);
         stg_flag[a] = d[15];
      end else if (a == 7 && d[15]) begin
         for (int i = 0; i < 7; i++) begin
            com_val[i] = stg_val[i];
            com_flag[i] = stg_flag[i];
         end
      end else if (a == 8) m_en = d[0];
      else if (a == 9 && d[0] && !set_now) m_st = 0;
      if (set_now) m_st = 1;
      #1;
      wr_en = 0; sec_tick = 0;
      check_all(tag);
   endtask

   task automatic do_tick(input string tag);
      @(negedge clk);
      sec_tick = 1;
      @(posedge clk);
      if (model_hit()) m_st = 1;
      #1;
      sec_tick = 0;
      check_all(tag);
   endtask

   task automatic cal_follow();
      for (int i = 0; i < 7; i++)
         cv[i] = com_flag[i] ? com_val[i][7:0] : 8'($urandom & fmask(i));
   endtask

   task automatic cal_random();
      for (int i = 0; i < 7; i++) cv[i] = 8'($urandom & fmask(i));
   endtask

   initial begin
      #2_000_000;
      if (!done) begin
         bad++;
         total++;
         $display("FAIL watchdog expired");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'h5eed_2024));
      for (int i = 0; i < 7; i++) begin
         stg_val[i] = 0; stg_flag[i] = 0; com_val[i] = 0; com_flag[i] = 0; cv[i] = 0;
      end
      m_en = 0; m_st = 0;
      repeat (3) @(posedge clk);
      #1 rst_n = 1;
      @(negedge clk);
      check_all("R1 reset");

      // staging, masking, commit
      do_write(0, 16'h80FF, "R2 stage only");
      do_write(7, 16'h0001, "R2 trigger w/o bit15");
      do_write(7, 16'h8000, "R3 R10 commit masked");

      // date alarm ignoring weekday
      do_write(0, 16'h8030, "R2");
      do_write(1, 16'h8015, "R2");
      do_write(2, 16'h8012, "R2");
      do_write(3, 16'h0003, "R2");
      do_write(4, 16'h8024, "R2");
      do_write(5, 16'h8011, "R2");
      do_write(6, 16'h8047, "R2");
      do_write(7, 16'h8000, "R3");
      do_write(8, 16'h0001, "R9 enable");
      cv[0] = 8'h30; cv[1] = 8'h15; cv[2] = 8'h12; cv[3] = 8'h05;
      cv[4] = 8'h24; cv[5] = 8'h11; cv[6] = 8'h47;
      repeat (2) begin
         @(negedge clk); @(posedge clk); #1;
         check_all("R5 no tick");
      end
      do_tick("R4 R6 weekday ignored");
      cv[0] = 8'h31;
      do_tick("R8 sticky on miss");
      do_write(9, 16'h0000, "R8 write zero");
      do_write(8, 16'h0000, "R9 gate off");
      do_write(9, 16'h0001, "R8 clear");
      cv[0] = 8'h30;
      // set and clear in the same cycle: set wins
      @(negedge clk); sec_tick = 1;
      do_write(9, 16'h0001, "R8 set beats clear");
      do_write(9, 16'h0001, "R8 clear");

      // no participating field
      for (int i = 0; i < 7; i++) do_write(i, 16'h0000, "R7");
      do_write(7, 16'h8000, "R7 commit");
      do_tick("R7 no flags");
      cal_random();
      do_tick("R7 no flags random");

      // constrained random
      for (int n = 0; n < 500; n++) begin
         int op;
         op = $urandom % 7;
         case (op)
            0, 1: do_write($urandom % 7, $urandom & 16'hFFFF, "R2 R10 rand field");
            2: do_write(7, ($urandom % 2) ? 16'h8000 : 16'h0000, "R3 rand trigger");
            3: begin cal_random(); do_tick("R4 R6 rand miss"); end
            4: begin cal_follow(); do_tick("R4 R6 R7 rand hit"); end
            5: do_write(9, $urandom % 2, "R8 rand clear");
            default: do_write(8, $urandom % 2, "R9 rand enable");
         endcase
      end

      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule